// File: doc/BRIEF.md
# Prioritized Interrupt CPU Interface

This block serves a single processor. It takes the enable and pending vectors of every interrupt source, along with an 8-bit priority per source, and finds the best candidate. That is the enabled, pending source with the numerically lowest priority; on a tie the lowest ID wins. It reports the candidate as the highest pending interrupt, compares it with a programmable priority mask and with the priority of the interrupt the processor is already running, and drives a registered interrupt request.

Acknowledge and end-of-interrupt requests arrive as single-cycle strobes.

- **Acknowledge.** When a candidate preempts, it becomes the running interrupt. The block emits a strobe that tells the external source tracker to clear that source's pending state, either for this processor only or for all processors.
- **Nesting.** Each preempted interrupt is remembered in a per-source predecessor link.
- **End-of-interrupt.**
  - Completing the running interrupt restores its predecessor.
  - Completing an interrupt deeper in the nest unlinks it from the chain. This takes a short multi-cycle walk, during which `busy` is high.
  - On completion, a level-type source whose line is still high is handed back to the tracker as pending.

ID 1023 stands for "none" throughout. A running priority of 0x100 means idle.

Top module: `pic_cpu_if`

## Requirements
- R1: After reset `irq` is 0, `hp_id` is 1023, `run_prio` is 0x100, `busy` is 0 and the priority mask is 0xF0.
- R2: Among sources with both enable and pending set, the lowest priority value is chosen; among equal priorities the lowest ID is chosen.
- R3: `hp_id` shows the chosen ID only when its priority is less than or equal to the 8-bit mask (written through `mask_we`/`mask_wdata`); otherwise it shows 1023.
- R4: `irq` is high exactly when a candidate is reported and its priority is strictly below `run_prio`. Both `irq` and `hp_id` are registered, so they reflect the inputs of the previous clock edge.
- R5: While `glb_en` or `cpu_en` is low, `irq` is 0 and `hp_id` is 1023.
- R6: An accepted acknowledge with a preempting candidate has the following effects on the next cycle:
  - `ack_vld` pulses and `ack_id` carries the candidate's ID.
  - `clr_stb` pulses with `clr_id` equal to that ID, and `clr_all` is set to the source's `src_all` bit.
  - `run_prio` becomes the candidate's priority.

  Without a preempting candidate, `ack_id` is 1023 and neither a strobe nor a state change occurs.
- R7: End-of-interrupt of the running ID makes its predecessor running, with `run_prio` equal to that predecessor's current priority, or 0x100 when there is none.
- R8: End-of-interrupt of a nested, non-running ID removes it from the predecessor chain while `run_prio` stays unchanged. A later completion of the running ID then skips the removed entry.
- R9: End-of-interrupt while nothing is running changes nothing and produces no strobe.
- R10: On end-of-interrupt, `set_stb` pulses with `set_id` equal to the completed ID when that source has all of the following:
  - `src_edge` = 0 (level type)
  - `src_en` = 1
  - `src_line` = 1
  - `src_tgt` = 1

  An edge-type source gives no pulse.
- R11: The completed ID is bits [9:0] of `eoi_wdata`; higher bits are ignored.
- R12: An acknowledge that arrives while `busy` is high, or in the same cycle as an end-of-interrupt, returns `ack_id` 1023 with `ack_vld` high and no state change. An end-of-interrupt takes precedence over an acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global distribution enable |
| cpu_en | input | 1 | Enable of this processor's interface |
| src_en | input | NUM_SRC | Per-source enable |
| src_pend | input | NUM_SRC | Per-source pending for this processor |
| src_prio | input | NUM_SRC*8 | Per-source priority, source i at bits [8i+7:8i] |
| src_edge | input | NUM_SRC | 1 = edge-type source, 0 = level-type |
| src_all | input | NUM_SRC | 1 = acknowledge clears pending for all processors |
| src_line | input | NUM_SRC | Current level of each source line |
| src_tgt | input | NUM_SRC | 1 = source targets this processor |
| mask_we | input | 1 | Priority mask write strobe |
| mask_wdata | input | 8 | Priority mask write value |
| ack_req | input | 1 | Acknowledge request strobe |
| eoi_req | input | 1 | End-of-interrupt request strobe |
| eoi_wdata | input | 32 | End-of-interrupt written value |
| irq | output | 1 | Interrupt request to the processor |
| hp_id | output | 10 | Highest pending ID, 1023 when none |
| run_prio | output | 9 | Running priority, 0x100 when idle |
| ack_vld | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged ID, 1023 when spurious |
| clr_stb | output | 1 | Pending-clear strobe to the source tracker |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for all processors |
| set_stb | output | 1 | Pending-set strobe for a level source still high |
| set_id | output | 10 | ID to set pending |
| busy | output | 1 | Chain unlink walk in progress |

## Verification
Acknowledge and end-of-interrupt are the two functions that can land in the same cycle. The same conflict arises when an acknowledge lands during the multi-cycle unlink walk that a non-running completion starts.

The bench provokes both while a preempting candidate is pending. It raises both strobes together, then raises a second acknowledge while `busy` is high. It judges each case at the ports: `ack_id` must be 1023 with no `clr_stb` and an unchanged `run_prio`, and a later plain acknowledge must still return the candidate. A sweep over arithmetic priority, enable, pending and mask patterns, with ties forced, covers the selection, masking and gating rules.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int          ID_W      = 10;
  localparam int          PRIO_W    = 8;
  localparam logic [9:0]  ID_NONE   = 10'h3FF;
  localparam logic [8:0]  PRIO_IDLE = 9'h100;
  localparam logic [7:0]  MASK_RST  = 8'hF0;

  typedef enum logic {
    ST_IDLE,
    ST_WALK
  } walk_st_t;
endpackage

// File: rtl/pic_select.sv
// Linear priority scan: a strictly smaller priority replaces the current
// choice, so equal priorities resolve to the lowest index.
module pic_select #(
  parameter int N  = 32,
  parameter int PW = 8,
  parameter int IW = 10
) (
  input  logic [N-1:0]    en,
  input  logic [N-1:0]    pend,
  input  logic [N*PW-1:0] prio,
  output logic            vld,
  output logic [IW-1:0]   id,
  output logic [PW-1:0]   prio_out
);
  always_comb begin
    vld      = 1'b0;
    id       = '1;
    prio_out = '1;
    for (int i = 0; i < N; i++) begin
      if (en[i] && pend[i] && (!vld || (prio[i*PW +: PW] < prio_out))) begin
        vld      = 1'b1;
        id       = IW'(i);
        prio_out = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/pic_chain.sv
// Predecessor link store, one entry per source. Asynchronous reads map to
// distributed RAM; an out-of-range address reads as all ones (none).
module pic_chain #(
  parameter int DEPTH = 32,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         we,
  input  logic [W-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ra_addr,
  output logic [W-1:0] ra_data,
  input  logic [W-1:0] rb_addr,
  output logic [W-1:0] rb_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr < W'(DEPTH))) mem[waddr[AW-1:0]] <= wdata;
  end

  assign ra_data = (ra_addr < W'(DEPTH)) ? mem[ra_addr[AW-1:0]] : '1;
  assign rb_data = (rb_addr < W'(DEPTH)) ? mem[rb_addr[AW-1:0]] : '1;
endmodule

// File: rtl/pic_cpu_if.sv
module pic_cpu_if #(
  parameter int NUM_SRC = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   glb_en,
  input  logic                   cpu_en,
  input  logic [NUM_SRC-1:0]     src_en,
  input  logic [NUM_SRC-1:0]     src_pend,
  input  logic [NUM_SRC*8-1:0]   src_prio,
  input  logic [NUM_SRC-1:0]     src_edge,
  input  logic [NUM_SRC-1:0]     src_all,
  input  logic [NUM_SRC-1:0]     src_line,
  input  logic [NUM_SRC-1:0]     src_tgt,
  input  logic                   mask_we,
  input  logic [7:0]             mask_wdata,
  input  logic                   ack_req,
  input  logic                   eoi_req,
  input  logic [31:0]            eoi_wdata,
  output logic                   irq,
  output logic [9:0]             hp_id,
  output logic [8:0]             run_prio,
  output logic                   ack_vld,
  output logic [9:0]             ack_id,
  output logic                   clr_stb,
  output logic [9:0]             clr_id,
  output logic                   clr_all,
  output logic                   set_stb,
  output logic [9:0]             set_id,
  output logic                   busy
);
  import pic_pkg::*;

  localparam int PW    = PRIO_W;
  localparam int IW    = ID_W;
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W = $clog2(NUM_SRC + 1);

  walk_st_t         st;
  logic [IW-1:0]    run_id;
  logic [PW-1:0]    mask_q;
  logic [IW-1:0]    walk_cur, walk_tgt;
  logic [CNT_W-1:0] walk_cnt;

  logic             best_vld;
  logic [IW-1:0]    best_id;
  logic [PW-1:0]    best_prio;
  logic             rep_ok, cand;

  logic [PW-1:0]    prio_arr [NUM_SRC];

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_prio
      assign prio_arr[g] = src_prio[g*PW +: PW];
    end
  endgenerate

  pic_select #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_sel (
    .en       (src_en),
    .pend     (src_pend),
    .prio     (src_prio),
    .vld      (best_vld),
    .id       (best_id),
    .prio_out (best_prio)
  );

  // Reporting and preemption decisions.
  assign rep_ok = glb_en && cpu_en && best_vld && (best_prio <= mask_q);
  assign cand   = rep_ok && ({1'b0, best_prio} < run_prio);

  // Link store ports.
  logic          ch_we;
  logic [IW-1:0] ch_waddr, ch_wdata, ch_ra, ch_rb, link_a, link_b;

  assign ch_ra = (st == ST_WALK) ? walk_cur : run_id;
  assign ch_rb = walk_tgt;

  pic_chain #(.DEPTH(NUM_SRC), .W(IW)) u_chain (
    .clk     (clk),
    .we      (ch_we),
    .waddr   (ch_waddr),
    .wdata   (ch_wdata),
    .ra_addr (ch_ra),
    .ra_data (link_a),
    .rb_addr (ch_rb),
    .rb_data (link_b)
  );

  // Request decode: completion has precedence over acknowledge.
  logic          acc_eoi, acc_ack, walk_hit;
  logic [IW-1:0] eoi_id;
  logic          eoi_in;
  logic [IDX_W-1:0] eoi_idx, best_idx, pred_idx;
  logic [PW-1:0] pred_prio;
  logic          repend_ok;
  logic          unused_bits;

  assign eoi_id      = eoi_wdata[IW-1:0];
  assign unused_bits = ^{eoi_wdata[31:IW], best_id[IW-1:IDX_W], link_a[IW-1:IDX_W], eoi_id[IW-1:IDX_W]};
  assign eoi_in      = eoi_id < IW'(NUM_SRC);
  assign eoi_idx     = eoi_id[IDX_W-1:0];
  assign best_idx    = best_id[IDX_W-1:0];
  assign pred_idx    = link_a[IDX_W-1:0];
  assign pred_prio   = prio_arr[pred_idx];

  assign acc_eoi  = eoi_req && (st == ST_IDLE);
  assign acc_ack  = ack_req && (st == ST_IDLE) && !eoi_req;
  assign walk_hit = (st == ST_WALK) && (link_a != ID_NONE) && (link_a == walk_tgt);

  assign repend_ok = eoi_in && !src_edge[eoi_idx] && src_en[eoi_idx] &&
                     src_line[eoi_idx] && src_tgt[eoi_idx];

  always_comb begin
    ch_we    = 1'b0;
    ch_waddr = best_id;
    ch_wdata = run_id;
    if (acc_ack && cand) begin
      ch_we = 1'b1;
    end else if (walk_hit) begin
      ch_we    = 1'b1;
      ch_waddr = walk_cur;
      ch_wdata = link_b;
    end
  end

  assign busy = (st == ST_WALK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      run_id   <= ID_NONE;
      run_prio <= PRIO_IDLE;
      mask_q   <= MASK_RST;
      irq      <= 1'b0;
      hp_id    <= ID_NONE;
      ack_vld  <= 1'b0;
      ack_id   <= ID_NONE;
      clr_stb  <= 1'b0;
      clr_id   <= ID_NONE;
      clr_all  <= 1'b0;
      set_stb  <= 1'b0;
      set_id   <= ID_NONE;
      walk_cur <= ID_NONE;
      walk_tgt <= ID_NONE;
      walk_cnt <= '0;
    end else begin
      irq     <= cand;
      hp_id   <= rep_ok ? best_id : ID_NONE;
      if (mask_we) mask_q <= mask_wdata;
      ack_vld <= ack_req;
      ack_id  <= ID_NONE;
      clr_stb <= 1'b0;
      set_stb <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (acc_eoi) begin
            if (run_id != ID_NONE) begin
              if (repend_ok) begin
                set_stb <= 1'b1;
                set_id  <= eoi_id;
              end
              if (eoi_id == run_id) begin
                run_id   <= link_a;
                run_prio <= (link_a == ID_NONE) ? PRIO_IDLE : {1'b0, pred_prio};
              end else begin
                st       <= ST_WALK;
                walk_cur <= run_id;
                walk_tgt <= eoi_id;
                walk_cnt <= '0;
              end
            end
          end else if (acc_ack && cand) begin
            ack_id   <= best_id;
            clr_stb  <= 1'b1;
            clr_id   <= best_id;
            clr_all  <= src_all[best_idx];
            run_id   <= best_id;
            run_prio <= {1'b0, best_prio};
          end
        end
        ST_WALK: begin
          if ((link_a == ID_NONE) || walk_hit ||
              (walk_cnt == CNT_W'(NUM_SRC - 1))) begin
            st <= ST_IDLE;
          end else begin
            walk_cur <= link_a;
            walk_cnt <= walk_cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_cpu_if_chk.sv
module pic_cpu_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       glb_en,
  input logic       cpu_en,
  input logic       ack_req,
  input logic       eoi_req,
  input logic       irq,
  input logic [9:0] hp_id,
  input logic [8:0] run_prio,
  input logic       ack_vld,
  input logic [9:0] ack_id,
  input logic       clr_stb,
  input logic [9:0] clr_id,
  input logic       busy
);
  assert_gate_off_R5: assert property (@(posedge clk) disable iff (rst)
    !(glb_en && cpu_en) |=> (!irq && hp_id == 10'h3FF));

  assert_clr_follows_ack_R6: assert property (@(posedge clk) disable iff (rst)
    clr_stb |-> (ack_vld && ack_id == clr_id));

  assert_ack_sets_prio_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack_id != 10'h3FF) |-> (run_prio < 9'h100));

  assert_ack_vld_origin_R6: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(ack_req));

  assert_walk_keeps_prio_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(run_prio));

  assert_collide_spurious_R12: assert property (@(posedge clk) disable iff (rst)
    (ack_req && (eoi_req || busy)) |=> (ack_vld && ack_id == 10'h3FF && !clr_stb));
endmodule

bind pic_cpu_if pic_cpu_if_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .glb_en   (glb_en),
  .cpu_en   (cpu_en),
  .ack_req  (ack_req),
  .eoi_req  (eoi_req),
  .irq      (irq),
  .hp_id    (hp_id),
  .run_prio (run_prio),
  .ack_vld  (ack_vld),
  .ack_id   (ack_id),
  .clr_stb  (clr_stb),
  .clr_id   (clr_id),
  .busy     (busy)
);

// File: tb/pic_cpu_if_tb.sv
`timescale 1ns/1ps
module pic_cpu_if_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, glb_en, cpu_en;
  logic [N-1:0]  src_en, src_pend, src_edge, src_all, src_line, src_tgt;
  logic [N*8-1:0] src_prio;
  logic          mask_we, ack_req, eoi_req;
  logic [7:0]    mask_wdata;
  logic [31:0]   eoi_wdata;
  logic          irq, ack_vld, clr_stb, clr_all, set_stb, busy;
  logic [9:0]    hp_id, ack_id, clr_id, set_id;
  logic [8:0]    run_prio;

  logic [7:0] m_prio [N];
  always_comb for (int i = 0; i < N; i++) src_prio[i*8 +: 8] = m_prio[i];

  pic_cpu_if #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .cpu_en(cpu_en),
    .src_en(src_en), .src_pend(src_pend), .src_prio(src_prio),
    .src_edge(src_edge), .src_all(src_all), .src_line(src_line), .src_tgt(src_tgt),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .ack_req(ack_req), .eoi_req(eoi_req), .eoi_wdata(eoi_wdata),
    .irq(irq), .hp_id(hp_id), .run_prio(run_prio),
    .ack_vld(ack_vld), .ack_id(ack_id),
    .clr_stb(clr_stb), .clr_id(clr_id), .clr_all(clr_all),
    .set_stb(set_stb), .set_id(set_id), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic ref_best(output int bid, output int bp);
    bid = 1023;
    bp  = 256;
    for (int i = 0; i < N; i++)
      if (src_en[i] && src_pend[i] && int'(m_prio[i]) < bp) begin
        bp  = int'(m_prio[i]);
        bid = i;
      end
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_we = 1'b1;
    mask_wdata = m;
    step;
    mask_we = 1'b0;
  endtask

  task automatic do_ack(input int exp_id, input int exp_rp, input string tag);
    ack_req = 1'b1;
    step;
    ack_req = 1'b0;
    chk({tag, " ack_vld"}, int'(ack_vld), 1);
    chk({tag, " ack_id"}, int'(ack_id), exp_id);
    chk({tag, " clr_stb"}, int'(clr_stb), (exp_id != 1023) ? 1 : 0);
    if (exp_id != 1023) chk({tag, " clr_id"}, int'(clr_id), exp_id);
    chk({tag, " run_prio"}, int'(run_prio), exp_rp);
  endtask

  task automatic do_eoi(input logic [31:0] w);
    eoi_req = 1'b1;
    eoi_wdata = w;
    step;
    eoi_req = 1'b0;
  endtask

  task automatic wait_idle;
    for (int k = 0; k < 40 && busy; k++) step;
    chk("R8 walk ends", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bid, bp, exp_hp, exp_irq;
    logic [7:0] m;
    rst = 1'b1; glb_en = 1'b1; cpu_en = 1'b1;
    src_en = '1; src_pend = '0; src_edge = '1; src_all = '0; src_line = '0; src_tgt = '1;
    mask_we = 1'b0; mask_wdata = '0; ack_req = 1'b0; eoi_req = 1'b0; eoi_wdata = '0;
    for (int i = 0; i < N; i++) m_prio[i] = 8'hE0;
    repeat (3) step;
    rst = 1'b0;
    step;

    // R1: reset values at the ports
    chk("R1 irq", int'(irq), 0);
    chk("R1 hp_id", int'(hp_id), 1023);
    chk("R1 run_prio", int'(run_prio), 256);
    chk("R1 busy", int'(busy), 0);

    // R1/R3: mask resets to 0xF0; 0xF1 excluded, 0xF0 included
    m_prio[0] = 8'hF1; src_pend = 8'h01;
    step;
    chk("R1 R3 mask 0xF1 excluded", int'(hp_id), 1023);
    m_prio[3] = 8'hF0; src_pend = 8'h09;
    step;
    chk("R1 R3 mask 0xF0 included", int'(hp_id), 3);
    chk("R4 irq idle", int'(irq), 1);

    // R2 R3 R4 R5: sweep of priority, enable, pending, mask and gate patterns
    for (int t = 0; t < 256; t++) begin
      for (int i = 0; i < N; i++) begin
        m_prio[i] = 8'(((t * 29) + (i * 71)) ^ (i << 3));
        if (t % 4 == 0) m_prio[i] = m_prio[i] & 8'hC0;
      end
      src_en   = 8'((t * 13) ^ 8'hA5);
      src_pend = 8'((t * 7) + 3);
      glb_en   = (t % 17 != 3);
      cpu_en   = (t % 11 != 5);
      m = (t % 3 == 0) ? 8'hFF : 8'((t * 11) & 8'hFF);
      write_mask(m);
      step;
      ref_best(bid, bp);
      exp_hp  = (glb_en && cpu_en && bid != 1023 && bp <= int'(m)) ? bid : 1023;
      exp_irq = (exp_hp != 1023) ? 1 : 0;
      chk("R2 R3 R5 hp_id sweep", int'(hp_id), exp_hp);
      chk("R4 R5 irq sweep", int'(irq), exp_irq);
    end

    // Nesting scenario
    glb_en = 1'b1; cpu_en = 1'b1; src_en = '1; src_pend = '0;
    for (int i = 0; i < N; i++) m_prio[i] = 8'hE0;
    m_prio[2] = 8'h80; m_prio[5] = 8'h40; m_prio[1] = 8'h20;
    src_line = '1; src_edge = 8'hFB; src_all = 8'h20; src_tgt = '1;
    write_mask(8'hF0);
    src_pend = 8'h04;
    step;
    chk("R4 irq src2", int'(irq), 1);
    chk("R2 hp src2", int'(hp_id), 2);
    do_ack(2, 8'h80, "R6 ack src2");
    chk("R6 clr_all src2", int'(clr_all), 0);
    src_pend = 8'h40;
    step;
    chk("R3 hp src6 under mask", int'(hp_id), 6);
    chk("R4 irq low, not below running", int'(irq), 0);
    do_ack(1023, 8'h80, "R6 spurious ack");
    src_pend = 8'h20;
    step;
    chk("R4 irq src5 preempts", int'(irq), 1);
    do_ack(5, 8'h40, "R6 ack src5");
    chk("R6 clr_all src5", int'(clr_all), 1);
    src_pend = 8'h02;
    step;
    do_ack(1, 8'h20, "R6 ack src1");
    src_pend = 8'h00;

    // R8: complete nested src5 out of order
    do_eoi(32'd5);
    chk("R8 busy during walk", int'(busy), 1);
    chk("R8 run_prio kept", int'(run_prio), 8'h20);
    chk("R10 no set for edge", int'(set_stb), 0);
    wait_idle();
    chk("R8 run_prio after walk", int'(run_prio), 8'h20);

    // R11 R7: upper bits ignored; running src1 completes, src5 skipped
    do_eoi(32'hFFFF_FC01);
    chk("R11 R7 R8 pred src2 restored", int'(run_prio), 8'h80);
    chk("R11 busy", int'(busy), 0);
    chk("R10 no set for edge src1", int'(set_stb), 0);

    // R7 R10: complete src2 (level, line high) -> idle and re-pend strobe
    do_eoi(32'd2);
    chk("R7 idle prio", int'(run_prio), 256);
    chk("R10 set_stb", int'(set_stb), 1);
    chk("R10 set_id", int'(set_id), 2);

    // R9: completion while idle is ignored
    do_eoi(32'd2);
    chk("R9 run_prio", int'(run_prio), 256);
    chk("R9 set_stb", int'(set_stb), 0);
    chk("R9 busy", int'(busy), 0);

    // R12: acknowledge collides with completion, then with the walk
    src_pend = 8'h04;
    step;
    do_ack(2, 8'h80, "R6 ack src2 again");
    src_pend = 8'h20;
    step;
    chk("R4 irq before collision", int'(irq), 1);
    ack_req = 1'b1; eoi_req = 1'b1; eoi_wdata = 32'd7;
    step;
    ack_req = 1'b0; eoi_req = 1'b0;
    chk("R12 same-cycle ack_vld", int'(ack_vld), 1);
    chk("R12 same-cycle ack_id", int'(ack_id), 1023);
    chk("R12 same-cycle clr_stb", int'(clr_stb), 0);
    chk("R12 busy after eoi", int'(busy), 1);
    ack_req = 1'b1;
    step;
    ack_req = 1'b0;
    chk("R12 busy ack_id", int'(ack_id), 1023);
    chk("R12 busy run_prio", int'(run_prio), 8'h80);
    wait_idle();
    do_ack(5, 8'h40, "R12 ack after collision");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule